// File: doc/BRIEF.md
# Trap Entry Controller

This block sits beside a processor pipeline and decides, once per clock, whether to enter a trap. It handles three kinds of request: a debug breakpoint, a level-sensitive set of interrupt lines, and a synchronous exception that arrives with a primary cause code and a sub-code. When it accepts a request, it does four things in one registered step. It saves the return context, rewrites the processor mode (privilege level, interrupt enable, direct-address and paging bits), records the cause, and presents a redirect program counter with a one-cycle valid strobe.

The block has three entry paths, and each saves its context into its own registers. The normal path serves interrupts and ordinary exceptions. The refill path serves exceptions raised while a translation refill is flagged. The debug path serves breakpoints, and interrupts that arrive while already in debug state. Exception and interrupt targets are spaced by a programmable power-of-two stride. Among the enabled pending lines, the highest-numbered one selects the interrupt vector. The surrounding core writes the mode and configuration registers through two simple write ports.

Top module: `trap_entry_ctrl`

## Requirements
- R1: After reset, the outputs hold these values:
  - `redir_pc` = 0x1C000000 and `redir_valid` = 0;
  - privilege 0, interrupt enable 0, direct addressing 1, paging 0;
  - the local enable mask and the vector spacing are both 0;
  - debug state and every saved or cause field are 0.
- R2: An interrupt is accepted only when all three of these hold:
  - the mode interrupt-enable bit is 1;
  - debug state is 0;
  - (`irq_in` AND local enable mask) is non-zero.
- R3: When several enabled lines are pending, the highest-numbered one selects the interrupt vector.
- R4: The stride is 0 when the spacing field is 0, and 4 << spacing otherwise. An interrupt redirects to `eentry` + (EXT_BASE + winning index) × stride, with EXT_BASE = 64 by default.
- R5: A synchronous exception without refill redirects to `eentry` + `exc_code` × stride.
- R6: A normal entry (interrupt, or exception without refill) saves the old privilege and enable into `prev_plv`/`prev_ie` and the PC into `ret_addr`. It writes the cause into `st_ecode`/`st_esub`: the exception's code and sub-code, or 0/0 for an interrupt.
- R7: An exception with `tlb_refill`=1 takes the refill path:
  - the old privilege and enable go to `rfl_prev_plv`/`rfl_prev_ie`;
  - direct addressing is set to 1 and paging to 0;
  - `rfl_ret` receives PC >> 2;
  - the redirect goes to `tlbr_entry`;
  - the normal-path save registers are left unchanged.
- R8: Each accepted request produces exactly one `redir_valid` pulse in the cycle after the request edge. The same edge forces privilege to 0 and interrupt enable to 0.
- R9: A breakpoint (`dbg_brk_req`) takes the debug path:
  - it sets the cause latch and writes debug code 0xC;
  - it saves the PC into `dbg_ret` and sets debug state;
  - it redirects to `eentry` + 0x480.
- R10: An enabled pending interrupt that arrives while debug state is 1 takes the debug path instead of the normal one. It sets `dbg_int_flag` and leaves `ret_addr` and the cause fields unchanged.
- R11: An accepted exception loads `bad_vaddr` with the PC only for these codes:
  - 0x0B to 0x12, that is system call, break, illegal instruction, privileged instruction, FP disabled, both vector-disabled codes and FP exception.
  - Any other code leaves `bad_vaddr` unchanged.
- R12: When requests coincide, the breakpoint wins over an interrupt, and an interrupt wins over an exception. A request that loses is dropped and leaves no trace.
- R13: A mode or configuration write takes effect at the next edge. On an entry edge, the entry's values override a mode write issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_pc | input | AW | PC of the requesting instruction |
| irq_in | input | NIRQ | Level interrupt lines |
| exc_req | input | 1 | Synchronous exception request |
| exc_code | input | 6 | Primary cause code |
| exc_sub | input | 9 | Cause sub-code |
| tlb_refill | input | 1 | Exception is a translation refill |
| dbg_brk_req | input | 1 | Debug breakpoint request |
| eentry | input | AW | Common entry base |
| tlbr_entry | input | AW | Refill entry address |
| wr_mode_en | input | 1 | Mode register write strobe |
| wr_plv | input | 2 | Privilege to write |
| wr_ie | input | 1 | Interrupt enable to write |
| wr_da | input | 1 | Direct-address bit to write |
| wr_pg | input | 1 | Paging bit to write |
| wr_cfg_en | input | 1 | Configuration write strobe |
| wr_lie | input | NIRQ | Local enable mask to write |
| wr_vs | input | VSW | Vector spacing to write |
| redir_valid | output | 1 | One-cycle redirect strobe |
| redir_pc | output | AW | Redirect target |
| mode_plv | output | 2 | Current privilege |
| mode_ie | output | 1 | Current interrupt enable |
| mode_da | output | 1 | Direct addressing |
| mode_pg | output | 1 | Paging |
| cfg_lie | output | NIRQ | Local enable mask |
| cfg_vs | output | VSW | Vector spacing |
| prev_plv | output | 2 | Saved privilege, normal path |
| prev_ie | output | 1 | Saved enable, normal path |
| st_ecode | output | 6 | Recorded primary cause |
| st_esub | output | 9 | Recorded sub-code |
| ret_addr | output | AW | Return address, normal path |
| bad_vaddr | output | AW | Faulting address |
| rfl_prev_plv | output | 2 | Saved privilege, refill path |
| rfl_prev_ie | output | 1 | Saved enable, refill path |
| rfl_ret | output | AW | Refill return, PC >> 2 |
| dbg_state | output | 1 | In debug state |
| dbg_cause_latch | output | 1 | Breakpoint cause latch |
| dbg_int_flag | output | 1 | Interrupt seen in debug state |
| dbg_ecode | output | 6 | Debug cause code |
| dbg_ret | output | AW | Debug return address |

## Verification
Several line patterns drive the interrupt path:
- lines {2,9,11} with mask bits {2,9} show whether the highest enabled index is chosen, rather than the highest raw line or the lowest enabled one;
- a mask that covers none of the pending lines separates "pending" from "pending and enabled";
- a zero spacing and two non-zero spacings show whether the stride formula and its zero case are applied.

Exceptions are tried with a code inside the faulting-address set and one outside it, and with the refill flag both clear and set, so the three save destinations are distinguished. Coincident breakpoint, interrupt, exception and mode-write requests, plus an interrupt taken in debug state, expose the priority order and the debug redirection.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int CODE_W = 6;
  localparam int SUB_W  = 9;

  localparam logic [CODE_W-1:0] CODE_INT        = 6'h00;
  localparam logic [CODE_W-1:0] CODE_SYSCALL    = 6'h0B;
  localparam logic [CODE_W-1:0] CODE_BREAK      = 6'h0C;
  localparam logic [CODE_W-1:0] CODE_ILLEGAL    = 6'h0D;
  localparam logic [CODE_W-1:0] CODE_PRIV_INSN  = 6'h0E;
  localparam logic [CODE_W-1:0] CODE_FP_OFF     = 6'h0F;
  localparam logic [CODE_W-1:0] CODE_VEC128_OFF = 6'h10;
  localparam logic [CODE_W-1:0] CODE_VEC256_OFF = 6'h11;
  localparam logic [CODE_W-1:0] CODE_FP_EXC     = 6'h12;
  localparam logic [CODE_W-1:0] CODE_DBG_BRK    = 6'h0C;

  typedef struct packed {
    logic       pg;
    logic       da;
    logic       ie;
    logic [1:0] plv;
  } mode_t;

  // Causes whose handler needs the PC as the faulting address
  function automatic logic loads_badv(input logic [CODE_W-1:0] c);
    case (c)
      CODE_SYSCALL, CODE_BREAK, CODE_ILLEGAL, CODE_PRIV_INSN,
      CODE_FP_OFF, CODE_VEC128_OFF, CODE_VEC256_OFF, CODE_FP_EXC: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/trap_irq_pick.sv
module trap_irq_pick #(
  parameter int NIRQ = 13,
  localparam int IDXW = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
  input  logic [NIRQ-1:0] pend,
  input  logic [NIRQ-1:0] mask,
  output logic            any,
  output logic [IDXW-1:0] idx
);
  logic [NIRQ-1:0] live;
  assign live = pend & mask;
  assign any  = |live;

  // Ascending scan: the last set bit seen is the highest index
  always_comb begin
    idx = '0;
    for (int i = 0; i < NIRQ; i++) begin
      if (live[i]) idx = IDXW'(i);
    end
  end
endmodule

// File: rtl/trap_vec_calc.sv
module trap_vec_calc #(
  parameter int AW       = 32,
  parameter int VSW      = 3,
  parameter int NIRQ     = 13,
  parameter int EXT_BASE = 64,
  localparam int IDXW = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
  input  logic [AW-1:0]              base,
  input  logic [VSW-1:0]             vs,
  input  logic                       use_irq,
  input  logic [IDXW-1:0]            irq_idx,
  input  logic [trap_pkg::CODE_W-1:0] code,
  output logic [AW-1:0]              target
);
  function automatic logic [AW-1:0] stride_of(input logic [VSW-1:0] s);
    return (s == '0) ? '0 : (AW'(4) << s);
  endfunction

  function automatic logic [AW-1:0] slot_of(input logic irq,
                                            input logic [IDXW-1:0] i,
                                            input logic [trap_pkg::CODE_W-1:0] c);
    return irq ? (AW'(EXT_BASE) + AW'(i)) : AW'(c);
  endfunction

  logic [AW-1:0] slot, stride;
  assign slot   = slot_of(use_irq, irq_idx, code);
  assign stride = stride_of(vs);
  assign target = base + slot * stride;
endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
  import trap_pkg::*;
#(
  parameter int          AW       = 32,
  parameter int          NIRQ     = 13,
  parameter int          VSW      = 3,
  parameter int          EXT_BASE = 64,
  parameter logic [31:0] RESET_PC = 32'h1C00_0000,
  parameter logic [31:0] DBG_OFS  = 32'h0000_0480,
  localparam int IDXW = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     cur_pc,
  input  logic [NIRQ-1:0]   irq_in,
  input  logic              exc_req,
  input  logic [5:0]        exc_code,
  input  logic [8:0]        exc_sub,
  input  logic              tlb_refill,
  input  logic              dbg_brk_req,
  input  logic [AW-1:0]     eentry,
  input  logic [AW-1:0]     tlbr_entry,
  input  logic              wr_mode_en,
  input  logic [1:0]        wr_plv,
  input  logic              wr_ie,
  input  logic              wr_da,
  input  logic              wr_pg,
  input  logic              wr_cfg_en,
  input  logic [NIRQ-1:0]   wr_lie,
  input  logic [VSW-1:0]    wr_vs,
  output logic              redir_valid,
  output logic [AW-1:0]     redir_pc,
  output logic [1:0]        mode_plv,
  output logic              mode_ie,
  output logic              mode_da,
  output logic              mode_pg,
  output logic [NIRQ-1:0]   cfg_lie,
  output logic [VSW-1:0]    cfg_vs,
  output logic [1:0]        prev_plv,
  output logic              prev_ie,
  output logic [5:0]        st_ecode,
  output logic [8:0]        st_esub,
  output logic [AW-1:0]     ret_addr,
  output logic [AW-1:0]     bad_vaddr,
  output logic [1:0]        rfl_prev_plv,
  output logic              rfl_prev_ie,
  output logic [AW-1:0]     rfl_ret,
  output logic              dbg_state,
  output logic              dbg_cause_latch,
  output logic              dbg_int_flag,
  output logic [5:0]        dbg_ecode,
  output logic [AW-1:0]     dbg_ret
);
  mode_t           mode_q;
  logic [NIRQ-1:0] lie_q;
  logic [VSW-1:0]  vs_q;

  // Named events for the checker
  logic            irq_any, irq_ok;
  logic [IDXW-1:0] irq_idx;
  logic            take_dbp, take_dbi, take_irq, take_exc, take_rfl, take_any;
  logic [AW-1:0]   vec_target, next_pc;

  trap_irq_pick #(.NIRQ(NIRQ)) u_pick (
    .pend(irq_in), .mask(lie_q), .any(irq_any), .idx(irq_idx)
  );

  trap_vec_calc #(.AW(AW), .VSW(VSW), .NIRQ(NIRQ), .EXT_BASE(EXT_BASE)) u_vec (
    .base(eentry), .vs(vs_q), .use_irq(take_irq), .irq_idx(irq_idx),
    .code(exc_code), .target(vec_target)
  );

  assign irq_ok   = mode_q.ie && irq_any;
  assign take_dbp = dbg_brk_req;
  assign take_dbi = !take_dbp && irq_ok && dbg_state;
  assign take_irq = !take_dbp && irq_ok && !dbg_state;
  assign take_exc = !take_dbp && !irq_ok && exc_req;
  assign take_rfl = take_exc && tlb_refill;
  assign take_any = take_dbp || take_dbi || take_irq || take_exc;

  always_comb begin
    if (take_dbp || take_dbi) next_pc = eentry + AW'(DBG_OFS);
    else if (take_rfl)        next_pc = tlbr_entry;
    else                      next_pc = vec_target;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redir_valid     <= 1'b0;
      redir_pc        <= AW'(RESET_PC);
      mode_q          <= '{pg: 1'b0, da: 1'b1, ie: 1'b0, plv: 2'd0};
      lie_q           <= '0;
      vs_q            <= '0;
      prev_plv        <= '0;
      prev_ie         <= 1'b0;
      st_ecode        <= '0;
      st_esub         <= '0;
      ret_addr        <= '0;
      bad_vaddr       <= '0;
      rfl_prev_plv    <= '0;
      rfl_prev_ie     <= 1'b0;
      rfl_ret         <= '0;
      dbg_state       <= 1'b0;
      dbg_cause_latch <= 1'b0;
      dbg_int_flag    <= 1'b0;
      dbg_ecode       <= '0;
      dbg_ret         <= '0;
    end else begin
      redir_valid <= take_any;
      if (take_any) redir_pc <= next_pc;

      if (take_any) begin
        mode_q.plv <= 2'd0;
        mode_q.ie  <= 1'b0;
        if (take_rfl) begin
          mode_q.da <= 1'b1;
          mode_q.pg <= 1'b0;
        end
      end else if (wr_mode_en) begin
        mode_q <= '{pg: wr_pg, da: wr_da, ie: wr_ie, plv: wr_plv};
      end

      if (wr_cfg_en) begin
        lie_q <= wr_lie;
        vs_q  <= wr_vs;
      end

      if (take_irq || (take_exc && !tlb_refill)) begin
        st_ecode <= take_irq ? CODE_INT : exc_code;
        st_esub  <= take_irq ? '0 : exc_sub;
        prev_plv <= mode_q.plv;
        prev_ie  <= mode_q.ie;
        ret_addr <= cur_pc;
      end

      if (take_rfl) begin
        rfl_prev_plv <= mode_q.plv;
        rfl_prev_ie  <= mode_q.ie;
        rfl_ret      <= cur_pc >> 2;
      end

      if (take_exc && loads_badv(exc_code)) bad_vaddr <= cur_pc;

      if (take_dbp || take_dbi) begin
        dbg_ret   <= cur_pc;
        dbg_state <= 1'b1;
      end
      if (take_dbp) begin
        dbg_cause_latch <= 1'b1;
        dbg_ecode       <= CODE_DBG_BRK;
      end
      if (take_dbi) dbg_int_flag <= 1'b1;
    end
  end

  assign mode_plv = mode_q.plv;
  assign mode_ie  = mode_q.ie;
  assign mode_da  = mode_q.da;
  assign mode_pg  = mode_q.pg;
  assign cfg_lie  = lie_q;
  assign cfg_vs   = vs_q;
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          exc_req,
  input logic          tlb_refill,
  input logic          dbg_brk_req,
  input logic          irq_any,
  input logic [AW-1:0] eentry,
  input logic [AW-1:0] tlbr_entry,
  input logic          redir_valid,
  input logic [AW-1:0] redir_pc,
  input logic [1:0]    mode_plv,
  input logic          mode_ie,
  input logic          mode_da,
  input logic          mode_pg,
  input logic          dbg_state
);
  AST_ENTRY_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> (mode_plv == 2'd0 && !mode_ie)); // R8

  AST_PULSE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(redir_valid) |-> $past(dbg_brk_req || exc_req || irq_any)); // R8

  AST_NO_IRQ_WHEN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_ie && !dbg_brk_req && !exc_req) |=> !redir_valid); // R2

  AST_DBG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_state |=> dbg_state); // R9

  AST_REFILL_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && tlb_refill && !dbg_brk_req && !mode_ie) |=>
      (mode_da && !mode_pg && redir_valid && redir_pc == $past(tlbr_entry))); // R7

  AST_DBG_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_brk_req |=> (dbg_state && redir_pc == $past(eentry) + AW'(32'h480))); // R9
endmodule

bind trap_entry_ctrl trap_entry_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .tlb_refill(tlb_refill),
  .dbg_brk_req(dbg_brk_req), .irq_any(irq_any), .eentry(eentry),
  .tlbr_entry(tlbr_entry), .redir_valid(redir_valid), .redir_pc(redir_pc),
  .mode_plv(mode_plv), .mode_ie(mode_ie), .mode_da(mode_da), .mode_pg(mode_pg),
  .dbg_state(dbg_state)
);

// File: tb/tb_trap_entry_ctrl.sv
module tb_trap_entry_ctrl;
  localparam int NIRQ = 13;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] cur_pc = '0, eentry = '0, tlbr_entry = '0;
  logic [NIRQ-1:0] irq_in = '0, wr_lie = '0;
  logic exc_req = 0, tlb_refill = 0, dbg_brk_req = 0;
  logic [5:0] exc_code = '0;
  logic [8:0] exc_sub = '0;
  logic wr_mode_en = 0, wr_ie = 0, wr_da = 0, wr_pg = 0, wr_cfg_en = 0;
  logic [1:0] wr_plv = '0;
  logic [2:0] wr_vs = '0;

  logic redir_valid, mode_ie, mode_da, mode_pg, prev_ie, rfl_prev_ie;
  logic dbg_state, dbg_cause_latch, dbg_int_flag;
  logic [31:0] redir_pc, ret_addr, bad_vaddr, rfl_ret, dbg_ret;
  logic [1:0] mode_plv, prev_plv, rfl_prev_plv;
  logic [NIRQ-1:0] cfg_lie;
  logic [2:0] cfg_vs;
  logic [5:0] st_ecode, dbg_ecode;
  logic [8:0] st_esub;

  trap_entry_ctrl dut (
    .clk, .rst_n, .cur_pc, .irq_in, .exc_req, .exc_code, .exc_sub, .tlb_refill,
    .dbg_brk_req, .eentry, .tlbr_entry, .wr_mode_en, .wr_plv, .wr_ie, .wr_da,
    .wr_pg, .wr_cfg_en, .wr_lie, .wr_vs, .redir_valid, .redir_pc, .mode_plv,
    .mode_ie, .mode_da, .mode_pg, .cfg_lie, .cfg_vs, .prev_plv, .prev_ie,
    .st_ecode, .st_esub, .ret_addr, .bad_vaddr, .rfl_prev_plv, .rfl_prev_ie,
    .rfl_ret, .dbg_state, .dbg_cause_latch, .dbg_int_flag, .dbg_ecode, .dbg_ret
  );

  always #10 clk = ~clk;

  int errors = 0, checks = 0;
  bit done = 0, cmp_on = 0;

  task automatic cmp(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  bit m_rv, m_ie, m_da, m_pg, m_pie, m_rie, m_dst, m_dcl, m_dei;
  bit [1:0] m_plv, m_pplv, m_rplv;
  bit [31:0] m_pc, m_era, m_badv, m_rera, m_dera;
  bit [NIRQ-1:0] m_lie;
  bit [2:0] m_vs;
  bit [5:0] m_ec, m_dec;
  bit [8:0] m_es;
  bit any, dbp, dbi, irq, exc;
  int idx;
  longint stride;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rv = 0; m_pc = 32'h1C00_0000; m_plv = 0; m_ie = 0; m_da = 1; m_pg = 0;
      m_lie = 0; m_vs = 0; m_pplv = 0; m_pie = 0; m_ec = 0; m_es = 0; m_era = 0;
      m_badv = 0; m_rplv = 0; m_rie = 0; m_rera = 0; m_dst = 0; m_dcl = 0;
      m_dei = 0; m_dec = 0; m_dera = 0;
    end else begin
      any = 0; idx = 0;
      for (int i = NIRQ - 1; i >= 0; i--)
        if (!any && irq_in[i] && m_lie[i]) begin any = 1; idx = i; end
      stride = (m_vs == 0) ? 0 : (64'd4 << m_vs);
      dbp = dbg_brk_req;
      dbi = !dbp && m_ie && any && m_dst;
      irq = !dbp && m_ie && any && !m_dst;
      exc = !dbp && !(m_ie && any) && exc_req;
      m_rv = dbp || dbi || irq || exc;
      if (exc && exc_code >= 6'h0B && exc_code <= 6'h12) m_badv = cur_pc;
      if (dbp || dbi) begin
        m_pc = eentry + 32'h480; m_dera = cur_pc; m_dst = 1;
        if (dbp) begin m_dcl = 1; m_dec = 6'hC; end else m_dei = 1;
      end else if (irq) begin
        m_pc = 32'(eentry + (64 + idx) * stride);
        m_ec = 0; m_es = 0; m_pplv = m_plv; m_pie = m_ie; m_era = cur_pc;
      end else if (exc && tlb_refill) begin
        m_rplv = m_plv; m_rie = m_ie; m_da = 1; m_pg = 0;
        m_rera = cur_pc / 4; m_pc = tlbr_entry;
      end else if (exc) begin
        m_pc = 32'(eentry + exc_code * stride);
        m_ec = exc_code; m_es = exc_sub; m_pplv = m_plv; m_pie = m_ie; m_era = cur_pc;
      end
      if (m_rv) begin m_plv = 0; m_ie = 0; end
      else if (wr_mode_en) begin m_plv = wr_plv; m_ie = wr_ie; m_da = wr_da; m_pg = wr_pg; end
      if (wr_cfg_en) begin m_lie = wr_lie; m_vs = wr_vs; end
    end
  end

  // Full comparison once per clock, away from the active edge
  always @(negedge clk) if (cmp_on && !done) begin
    cmp("R8", "redir_valid", redir_valid, m_rv);
    cmp("R4", "redir_pc", redir_pc, m_pc);
    cmp("R13", "mode_plv", mode_plv, m_plv);
    cmp("R13", "mode_ie", mode_ie, m_ie);
    cmp("R7", "mode_da", mode_da, m_da);
    cmp("R7", "mode_pg", mode_pg, m_pg);
    cmp("R13", "cfg_lie", cfg_lie, m_lie);
    cmp("R13", "cfg_vs", cfg_vs, m_vs);
    cmp("R6", "prev_plv", prev_plv, m_pplv);
    cmp("R6", "prev_ie", prev_ie, m_pie);
    cmp("R6", "st_ecode", st_ecode, m_ec);
    cmp("R6", "st_esub", st_esub, m_es);
    cmp("R6", "ret_addr", ret_addr, m_era);
    cmp("R11", "bad_vaddr", bad_vaddr, m_badv);
    cmp("R7", "rfl_prev_plv", rfl_prev_plv, m_rplv);
    cmp("R7", "rfl_prev_ie", rfl_prev_ie, m_rie);
    cmp("R7", "rfl_ret", rfl_ret, m_rera);
    cmp("R9", "dbg_state", dbg_state, m_dst);
    cmp("R9", "dbg_cause_latch", dbg_cause_latch, m_dcl);
    cmp("R10", "dbg_int_flag", dbg_int_flag, m_dei);
    cmp("R9", "dbg_ecode", dbg_ecode, m_dec);
    cmp("R9", "dbg_ret", dbg_ret, m_dera);
  end

  task automatic step(input int n = 1);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic idle();
    exc_req = 0; tlb_refill = 0; dbg_brk_req = 0; wr_mode_en = 0; wr_cfg_en = 0;
  endtask

  task automatic wmode(input bit [1:0] p, input bit ie, input bit da, input bit pg);
    wr_mode_en = 1; wr_plv = p; wr_ie = ie; wr_da = da; wr_pg = pg;
    step(); wr_mode_en = 0;
  endtask

  task automatic wcfg(input bit [NIRQ-1:0] l, input bit [2:0] v);
    wr_cfg_en = 1; wr_lie = l; wr_vs = v;
    step(); wr_cfg_en = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (4000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    step(2);
    // R1 reset state
    cmp("R1", "reset redir_pc", redir_pc, 32'h1C00_0000);
    cmp("R1", "reset redir_valid", redir_valid, 0);
    cmp("R1", "reset da/pg/ie/plv", {mode_da, mode_pg, mode_ie, mode_plv}, 5'b10000);
    cmp("R1", "reset lie/vs", {cfg_lie, cfg_vs}, 0);
    cmp("R1", "reset dbg_state", dbg_state, 0);
    rst_n = 1; cmp_on = 1;
    eentry = 32'h8000_0000; tlbr_entry = 32'h9000_0000;
    step();
    wcfg(13'h204, 3'd2);

    // R5/R11/R6 syscall exception
    cur_pc = 32'h1000; exc_code = 6'h0B; exc_sub = 9'h3; exc_req = 1;
    step(); idle();
    cmp("R5", "syscall target", redir_pc, 32'h8000_00B0);
    cmp("R11", "badv loaded", bad_vaddr, 32'h1000);
    cmp("R6", "ecode", st_ecode, 6'h0B);
    step();
    cmp("R8", "single pulse", redir_valid, 0);

    // R11 code outside the set leaves bad_vaddr
    cur_pc = 32'h2000; exc_code = 6'h03; exc_sub = 9'h5; exc_req = 1;
    step(); idle();
    cmp("R11", "badv kept", bad_vaddr, 32'h1000);
    cmp("R6", "ret_addr", ret_addr, 32'h2000);

    // R2 interrupt with enable off
    irq_in = 13'h0A04; step(3);
    cmp("R2", "no entry with ie=0", redir_valid, 0);
    wmode(2'd3, 1, 1, 0);
    cmp("R13", "write visible", mode_ie, 1);
    step();
    cmp("R3", "highest enabled wins", redir_pc, 32'h8000_0490);
    cmp("R6", "prev plv", prev_plv, 2'd3);
    cmp("R8", "plv forced 0", mode_plv, 0);

    // R4 zero spacing
    wcfg(13'h204, 3'd0);
    wmode(2'd0, 1, 1, 0);
    step();
    cmp("R4", "zero stride", redir_pc, 32'h8000_0000);

    // R2 mask excludes every pending line
    wcfg(13'h001, 3'd1);
    wmode(2'd0, 1, 1, 0);
    step(2);
    cmp("R2", "masked lines ignored", redir_valid, 0);
    cmp("R2", "enable kept", mode_ie, 1);
    irq_in = '0;

    // R7 refill path
    wmode(2'd2, 0, 0, 1);
    cur_pc = 32'h3004; exc_code = 6'h01; tlb_refill = 1; exc_req = 1;
    step(); idle();
    cmp("R7", "refill target", redir_pc, 32'h9000_0000);
    cmp("R7", "refill ret", rfl_ret, 32'h0C01);
    cmp("R7", "refill da/pg", {mode_da, mode_pg}, 2'b10);
    cmp("R7", "refill prev plv", rfl_prev_plv, 2'd2);

    // R12 interrupt beats exception
    wcfg(13'h204, 3'd1);
    wmode(2'd0, 1, 1, 0);
    irq_in = 13'h004; cur_pc = 32'h4000; exc_code = 6'h0D; exc_req = 1;
    step(); idle(); irq_in = '0;
    cmp("R12", "irq over exc", redir_pc, 32'h8000_0210);
    cmp("R12", "exc dropped", bad_vaddr, 32'h1000);

    // R9/R12/R13 breakpoint beats all, mode write ignored
    wmode(2'd0, 1, 1, 0);
    irq_in = 13'h004; cur_pc = 32'h5000; exc_req = 1; dbg_brk_req = 1;
    wr_mode_en = 1; wr_plv = 2'd1; wr_ie = 1; wr_da = 1; wr_pg = 0;
    step(); idle(); irq_in = '0;
    cmp("R9", "debug target", redir_pc, 32'h8000_0480);
    cmp("R9", "debug code", dbg_ecode, 6'hC);
    cmp("R9", "dbg_ret", dbg_ret, 32'h5000);
    cmp("R13", "write overridden", {mode_plv, mode_ie}, 3'b000);

    // R10 interrupt while in debug state
    wmode(2'd0, 1, 1, 0);
    irq_in = 13'h200; cur_pc = 32'h6000;
    step(); irq_in = '0;
    cmp("R10", "debug int target", redir_pc, 32'h8000_0480);
    cmp("R10", "debug int flag", dbg_int_flag, 1);
    cmp("R10", "ret_addr unchanged", ret_addr, 32'h4000);
    step(2);
    finish_run();
  end
endmodule